// File: doc/BRIEF.md
# Decoder Event Serial Transmitter

This block reports decoder activity to a host microcontroller over a short serial frame. Whenever the decoder accepts a valid code, it pulses a send strobe. The transmitter then captures the function bits, the battery-low flag, the repeat flag and the learned-transmitter count, and shifts them out as a ten-bit event frame. After the second stage of a learn operation, the strobe is raised with the frame-type select set to status. The block then sends a learn-status frame of the same length. That frame carries the learn result, the overwrite flag and the count.

Each frame goes out in one of two line modes, chosen at the strobe. The single-wire mode sends every bit as a pulse-width-coded symbol of three equal elements on the data line. The two-wire mode drives a clock beside the data line. Data changes with the rising clock edge, and the host samples on the falling edge. The element length is a parameter in clock cycles, so one design serves both real-time pulse widths and short simulation pulses. A busy output covers the whole frame. While busy is high, further strobes and input changes have no effect.

Top module: `evt_serial_tx`

## Requirements
- R1: After reset, `data_o`, `sclk_o` and `busy_o` are all 0.
- R2: With `kind_i`=0, the frame is sent first-to-last as: start(1), S3, S2, S1, S0 (`func_i[3]` down to `func_i[0]`), battery-low, repeat, `txcnt_i[1]`, `txcnt_i[0]`, stop(1).
- R3: With `kind_i`=1, the frame is sent first-to-last as: start(1), 0, 0, 0, 0, learn result, `txcnt_i[1]`, `txcnt_i[0]`, overwrite, stop(1). `txcnt_i` holds the number of learned transmitters minus one (00 = one, 11 = four).
- R4: With `mode_i`=0 (single wire), each bit lasts three elements of `ELEM_CYC` cycles each. A 1 is sent as high, low, low. A 0 is sent as high, high, low. `sclk_o` stays 0.
- R5: With `mode_i`=1 (two wire), each bit lasts two elements. `sclk_o` is 1 during the first element and 0 during the second. `data_o` holds the bit value for the whole bit and changes only together with a rising edge of `sclk_o`.
- R6: `busy_o` rises in the cycle after an accepted strobe. It stays 1 for exactly 30·`ELEM_CYC` cycles in single-wire mode, or 20·`ELEM_CYC` cycles in two-wire mode, and then falls.
- R7: A strobe while `busy_o`=1 is ignored, and changes to any data, kind or mode input during a frame do not alter that frame.
- R8: While `busy_o`=0, `data_o` and `sclk_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| send_i | input | 1 | Send strobe; accepted when not busy |
| kind_i | input | 1 | Frame type: 0 event, 1 learn status |
| mode_i | input | 1 | Line mode: 0 single-wire PWM, 1 two-wire clocked |
| func_i | input | 4 | Function bits S3..S0 |
| batt_low_i | input | 1 | Battery-low flag |
| repeat_i | input | 1 | Repeated-transmission flag |
| learn_ok_i | input | 1 | Learn result (1 = success) |
| overwrite_i | input | 1 | Earlier transmitter replaced |
| txcnt_i | input | 2 | Learned transmitters minus one |
| data_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock (two-wire mode) |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench builds the block with `ELEM_CYC` = 3. A single-wire frame is then 90 cycles and a two-wire frame is 60 cycles. This lets every cycle of a few dozen frames, in both modes and both frame types, be compared against a bench model. Three cycles per element also exercise the element counter's wrap and mid-count states. A one-cycle element would hide those states.

// File: rtl/evt_tx_pkg.sv
package evt_tx_pkg;

  localparam int FRAME_BITS = 10;

  typedef enum logic {FR_EVENT = 1'b0, FR_STATUS = 1'b1} frame_kind_e;
  typedef enum logic {LINE_PWM = 1'b0, LINE_CLOCKED = 1'b1} line_mode_e;

  // Frame vector: bit [FRAME_BITS-1] leaves the wire first.
  function automatic logic [FRAME_BITS-1:0] pack_event(
      input logic [3:0] fn, input logic vlow, input logic rpt, input logic [1:0] cnt);
    return {1'b1, fn, vlow, rpt, cnt, 1'b1};
  endfunction

  function automatic logic [FRAME_BITS-1:0] pack_status(
      input logic ok, input logic ovr, input logic [1:0] cnt);
    return {1'b1, 4'b0000, ok, cnt, ovr, 1'b1};
  endfunction

  // Single-wire symbol: element 0 high, element 1 high only for a zero, element 2 low.
  function automatic logic pwm_level(input logic bit_v, input logic [1:0] elem);
    case (elem)
      2'd0:    return 1'b1;
      2'd1:    return ~bit_v;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/evt_frame_build.sv
module evt_frame_build
  import evt_tx_pkg::*;
(
  input  logic                  kind,
  input  logic [3:0]            func,
  input  logic                  batt_low,
  input  logic                  rpt,
  input  logic                  learn_ok,
  input  logic                  overwrite,
  input  logic [1:0]            txcnt,
  output logic [FRAME_BITS-1:0] frame
);
  always_comb begin
    if (frame_kind_e'(kind) == FR_STATUS) frame = pack_status(learn_ok, overwrite, txcnt);
    else                                  frame = pack_event(func, batt_low, rpt, txcnt);
  end
endmodule

// File: rtl/evt_bit_seq.sv
module evt_bit_seq
  import evt_tx_pkg::*;
#(
  parameter int ELEM_CYC = 1600
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                two_wire,
  output logic                busy,
  output logic [3:0]          bit_idx,
  output logic [1:0]          elem_idx,
  output logic                elem_end,
  output logic                frame_end
);
  localparam int CNT_W = (ELEM_CYC < 2) ? 1 : $clog2(ELEM_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ELEM_CYC - 1);
  localparam logic [3:0]       BIT_LAST = 4'(FRAME_BITS - 1);

  logic [CNT_W-1:0] cnt;
  logic [1:0]       elem_last;

  assign elem_last = two_wire ? 2'd1 : 2'd2;
  assign elem_end  = busy && (cnt == CNT_LAST);
  assign frame_end = elem_end && (elem_idx == elem_last) && (bit_idx == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      bit_idx  <= '0;
      elem_idx <= '0;
      cnt      <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      bit_idx  <= '0;
      elem_idx <= '0;
      cnt      <= '0;
    end else if (busy) begin
      if (elem_end) begin
        cnt <= '0;
        if (elem_idx == elem_last) begin
          elem_idx <= '0;
          if (bit_idx == BIT_LAST) busy <= 1'b0;
          else                     bit_idx <= bit_idx + 4'd1;
        end else begin
          elem_idx <= elem_idx + 2'd1;
        end
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R6
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx <= BIT_LAST);

  // R4
  elem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elem_idx <= elem_last);

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !frame_end |=> busy);

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !start |=> !busy);
endmodule

// File: rtl/evt_line_drive.sv
module evt_line_drive
  import evt_tx_pkg::*;
(
  input  logic [FRAME_BITS-1:0] frame,
  input  logic [3:0]            bit_idx,
  input  logic [1:0]            elem_idx,
  input  logic                  busy,
  input  logic                  two_wire,
  output logic                  data,
  output logic                  sclk
);
  logic [3:0] pos;
  logic       bit_v;

  assign pos   = 4'(FRAME_BITS - 1) - bit_idx;
  assign bit_v = frame[pos];

  always_comb begin
    if (!busy) begin
      data = 1'b0;
      sclk = 1'b0;
    end else if (two_wire) begin
      data = bit_v;
      sclk = (elem_idx == 2'd0);
    end else begin
      data = pwm_level(bit_v, elem_idx);
      sclk = 1'b0;
    end
  end
endmodule

// File: rtl/evt_serial_tx.sv
module evt_serial_tx
  import evt_tx_pkg::*;
#(
  parameter int ELEM_CYC = 1600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       send_i,
  input  logic       kind_i,
  input  logic       mode_i,
  input  logic [3:0] func_i,
  input  logic       batt_low_i,
  input  logic       repeat_i,
  input  logic       learn_ok_i,
  input  logic       overwrite_i,
  input  logic [1:0] txcnt_i,
  output logic       data_o,
  output logic       sclk_o,
  output logic       busy_o
);
  logic [FRAME_BITS-1:0] frame_next, frame_q;
  logic                  two_wire_q;
  logic                  accept;
  logic [3:0]            bit_idx;
  logic [1:0]            elem_idx;
  logic                  elem_end, frame_end;

  assign accept = send_i && !busy_o;

  evt_frame_build u_build (
    .kind(kind_i), .func(func_i), .batt_low(batt_low_i), .rpt(repeat_i),
    .learn_ok(learn_ok_i), .overwrite(overwrite_i), .txcnt(txcnt_i),
    .frame(frame_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q    <= '0;
      two_wire_q <= 1'b0;
    end else if (accept) begin
      frame_q    <= frame_next;
      two_wire_q <= (line_mode_e'(mode_i) == LINE_CLOCKED);
    end
  end

  evt_bit_seq #(.ELEM_CYC(ELEM_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .two_wire(two_wire_q),
    .busy(busy_o), .bit_idx(bit_idx), .elem_idx(elem_idx),
    .elem_end(elem_end), .frame_end(frame_end)
  );

  evt_line_drive u_drive (
    .frame(frame_q), .bit_idx(bit_idx), .elem_idx(elem_idx), .busy(busy_o),
    .two_wire(two_wire_q), .data(data_o), .sclk(sclk_o)
  );

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_i && !busy_o |=> busy_o);

  // R2
  start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> data_o);

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(frame_q) && $stable(two_wire_q));

  // R4
  pwm_noclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !two_wire_q |-> !sclk_o);

  // R5
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) && two_wire_q && !$rose(sclk_o) |-> $stable(data_o));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !data_o && !sclk_o);
endmodule

// File: tb/sim_evt_serial_tx.sv
module sim_evt_serial_tx;
  localparam int E = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic send_i = 1'b0, kind_i = 1'b0, mode_i = 1'b0;
  logic [3:0] func_i = '0;
  logic batt_low_i = 1'b0, repeat_i = 1'b0, learn_ok_i = 1'b0, overwrite_i = 1'b0;
  logic [1:0] txcnt_i = '0;
  logic data_o, sclk_o, busy_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_serial_tx #(.ELEM_CYC(E)) u0 (
    .clk(clk), .rst_n(rst_n), .send_i(send_i), .kind_i(kind_i), .mode_i(mode_i),
    .func_i(func_i), .batt_low_i(batt_low_i), .repeat_i(repeat_i),
    .learn_ok_i(learn_ok_i), .overwrite_i(overwrite_i), .txcnt_i(txcnt_i),
    .data_o(data_o), .sclk_o(sclk_o), .busy_o(busy_o)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", tag, what, cyc, act, exp);
    end
  endtask

  // Bench model: bit b of the frame, b=0 is the first bit on the wire.
  function automatic logic model_bit(input int b, input logic k, input logic [3:0] fn,
      input logic vl, input logic rp, input logic ok, input logic ov, input logic [1:0] cn);
    logic seq [10];
    seq[0] = 1'b1; seq[9] = 1'b1;
    if (!k) begin
      for (int i = 0; i < 4; i++) seq[1+i] = fn[3-i];
      seq[5] = vl; seq[6] = rp; seq[7] = cn[1]; seq[8] = cn[0];
    end else begin
      for (int i = 1; i <= 4; i++) seq[i] = 1'b0;
      seq[5] = ok; seq[6] = cn[1]; seq[7] = cn[0]; seq[8] = ov;
    end
    return seq[b];
  endfunction

  task automatic send_frame(input logic k, input logic md, input logic [3:0] fn,
      input logic vl, input logic rp, input logic ok, input logic ov, input logic [1:0] cn,
      input bit poke);
    int total, per;
    string ftag, mtag, btag;
    total = md ? 20*E : 30*E;
    per   = md ? 2 : 3;
    ftag  = k ? "R3" : "R2";
    mtag  = md ? "R5" : "R4";
    btag  = poke ? "R7" : "R6";
    @(negedge clk);
    kind_i = k; mode_i = md; func_i = fn; batt_low_i = vl; repeat_i = rp;
    learn_ok_i = ok; overwrite_i = ov; txcnt_i = cn; send_i = 1'b1;
    @(negedge clk);
    send_i = 1'b0;
    for (int t = 0; t < total + 3; t++) begin
      if (t < total) begin
        int e, b, ph;
        logic v, ed, es;
        e = t / E; b = e / per; ph = e % per;
        v = model_bit(b, k, fn, vl, rp, ok, ov, cn);
        if (md) begin
          ed = v; es = (ph == 0);
        end else begin
          ed = (ph == 0) || (ph == 1 && !v); es = 1'b0;
        end
        check({ftag, "+", mtag}, "data", data_o, ed);
        check(mtag, "sclk", sclk_o, es);
        check(btag, "busy", busy_o, 1'b1);
      end else begin
        check(btag, "busy end", busy_o, 1'b0);
        check("R8", "idle data", data_o, 1'b0);
        check("R8", "idle sclk", sclk_o, 1'b0);
      end
      @(negedge clk);
      if (poke) begin
        if (t == 4) send_i = 1'b1;
        if (t == 5) begin
          send_i = 1'b0;
          kind_i = ~k; mode_i = ~md; func_i = ~fn; batt_low_i = ~vl; repeat_i = ~rp;
          learn_ok_i = ~ok; overwrite_i = ~ov; txcnt_i = ~cn;
        end
      end
    end
  endtask

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset data", data_o, 1'b0);
    check("R1", "reset sclk", sclk_o, 1'b0);
    check("R1", "reset busy", busy_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8", "idle after reset", data_o | sclk_o | busy_o, 1'b0);

    // Directed corners: all-ones / all-zeros events, status in both modes.
    send_frame(1'b0, 1'b0, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0);
    send_frame(1'b0, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
    send_frame(1'b1, 1'b0, 4'hA, 1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0);
    send_frame(1'b1, 1'b1, 4'h5, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0);
    // R7: strobe and input changes mid-frame, both modes
    send_frame(1'b0, 1'b0, 4'h9, 1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1);
    send_frame(1'b1, 1'b1, 4'h3, 1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 1'b1);

    for (int n = 0; n < 24; n++) begin
      logic [31:0] r;
      r = $urandom;
      send_frame(r[0], r[1], r[5:2], r[6], r[7], r[8], r[9], r[11:10], r[12]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule